// File: doc/BRIEF.md
# Serial Identity Emitter and CRC-8 Checker

The block holds a fixed 64-bit device identity and sends it out one bit per shift strobe, least significant bit first. The identity's low byte is an 8-bit family code and its middle 48 bits are a serial number. Its top byte is a CRC-8, which is derived from those 56 bits when the design is elaborated. The family code and serial number are parameters.

A bit-serial CRC-8 accumulator runs next to the serialiser and is fed by it. In emit mode the accumulator takes the block's own outgoing bits. After 56 strobes it holds the CRC byte, and after 64 strobes it returns to zero. In check mode the accumulator takes bits from a receive input instead. The match flag then shows whether a complete 64-bit identity from elsewhere leaves a zero residue. A synchronous clear restarts both the accumulator and the bit position, so that a new sequence can begin.

Top module: `serial_id_crc`

## Requirements
- R1: Identity bit n is presented on tx_bit_o while n shifts have been taken since clear or reset (0 <= n <= 63). Bits 0..7 carry the family code (default 0x0F). Bits 8..55 carry the serial number, and bits 56..63 carry the CRC. Once 64 shifts have been taken, tx_bit_o is 1.
- R2: The CRC is accumulated from zero, least significant bit first. Each bit is taken as follows: feedback = crc[0] XOR input bit, the register shifts right, and 0x8C is XORed in when feedback is 1. While exactly 56 shifts have been taken, crc_ready_o is 1 and crc_o holds the CRC of the bits shifted so far. For the block's own identity, this value equals identity bits 63..56.
- R3: A cycle with shift_i low leaves crc_o, tx_bit_o, crc_ready_o and match_o unchanged.
- R4: clear_i high at a clock edge zeroes the CRC and the shift count. This takes priority over a shift_i strobe in the same cycle.
- R5: match_o is 1 exactly when 64 shifts have been taken and crc_o is zero. With fewer shifts it is 0, even when the residue is zero.
- R6: After 64 shifts, further shift_i strobes change neither crc_o nor match_o.
- R7: After reset, crc_o is 0x00, crc_ready_o and match_o are 0, and tx_bit_o shows identity bit 0.
- R8: With check_mode_i = 0 the accumulator takes tx_bit_o, so a full emitted identity ends with match_o = 1 and crc_o = 0x00. With check_mode_i = 1 it takes rx_bit_i, and any single flipped bit of a valid identity ends with match_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Synchronous restart of CRC and bit position |
| shift_i | input | 1 | One-cycle bit strobe |
| check_mode_i | input | 1 | 0: accumulate own output, 1: accumulate rx_bit_i |
| rx_bit_i | input | 1 | Received identity bit for check mode |
| tx_bit_o | output | 1 | Current identity bit |
| crc_o | output | 8 | CRC accumulator value |
| crc_ready_o | output | 1 | Exactly 56 bits taken; crc_o is the identity CRC |
| match_o | output | 1 | 64 bits taken with zero residue |

## Verification
The assertions assume that shift_i and clear_i are synchronous single-cycle levels. They also assume that check_mode_i and rx_bit_i are settled before the edge on which a strobe is taken. A strobe arriving together with a clear is assumed to be discarded. The bench drives every input on the falling edge and keeps each strobe one cycle wide. It holds the mode constant within an identity and restarts each sequence with a clear, so that the shift count always starts from zero.

// File: rtl/id_crc_pkg.sv
package id_crc_pkg;
  localparam int FAM_W = 8;
  localparam int SER_W = 48;
  localparam int CRC_W = 8;
  localparam int PAY_W = FAM_W + SER_W;
  localparam int ID_W  = PAY_W + CRC_W;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 8'h8C;

  function automatic logic [CRC_W-1:0] crc8_step(input logic [CRC_W-1:0] crc,
                                                 input logic din);
    logic [CRC_W-1:0] nxt;
    nxt = crc >> 1;
    if (crc[0] ^ din) nxt = nxt ^ CRC_POLY_REFL;
    return nxt;
  endfunction

  function automatic logic [CRC_W-1:0] crc8_over(input logic [PAY_W-1:0] d);
    logic [CRC_W-1:0] c;
    c = '0;
    for (int i = 0; i < PAY_W; i++) c = crc8_step(c, d[i]);
    return c;
  endfunction
endpackage

// File: rtl/id_bit_counter.sv
module id_bit_counter
  import id_crc_pkg::*;
#(
  parameter int NBITS = ID_W,
  parameter int READY_AT = PAY_W,
  localparam int CNT_W = $clog2(NBITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             shift_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             ready_o
);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(NBITS);
  localparam logic [CNT_W-1:0] READY_CNT = CNT_W'(READY_AT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clear_i)                   cnt_q <= '0;
    else if (shift_i && cnt_q != FULL_CNT) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign full_o  = (cnt_q == FULL_CNT);
  assign ready_o = (cnt_q == READY_CNT);

  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);
  p_cnt_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !clear_i && cnt_q != FULL_CNT) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_cnt_sat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !clear_i) |=> full_o);
endmodule

// File: rtl/crc8_shifter.sv
module crc8_shifter
  import id_crc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             din_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (clear_i) crc_q <= '0;
    else if (step_i)  crc_q <= crc8_step(crc_q, din_i);
  end

  assign crc_o = crc_q;

  p_crc_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clear_i) |=> $stable(crc_q));
  p_crc_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> crc_q == '0);
endmodule

// File: rtl/id_serializer.sv
module id_serializer
  import id_crc_pkg::*;
#(
  parameter logic [ID_W-1:0] IDENT = '0,
  localparam int CNT_W = $clog2(ID_W + 1),
  localparam int IDX_W = $clog2(ID_W)
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             full_i,
  output logic             bit_o
);
  // idle-high once the whole identity is out
  assign bit_o = full_i ? 1'b1 : IDENT[cnt_i[IDX_W-1:0]];
endmodule

// File: rtl/serial_id_crc.sv
module serial_id_crc
  import id_crc_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY_CODE = 8'h0F,
  parameter logic [SER_W-1:0] SERIAL_NUM  = 48'h0000_0000_0001
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             shift_i,
  input  logic             check_mode_i,
  input  logic             rx_bit_i,
  output logic             tx_bit_o,
  output logic [CRC_W-1:0] crc_o,
  output logic             crc_ready_o,
  output logic             match_o
);
  localparam int CNT_W = $clog2(ID_W + 1);
  localparam logic [PAY_W-1:0] PAYLOAD = {SERIAL_NUM, FAMILY_CODE};
  localparam logic [ID_W-1:0]  IDENT   = {crc8_over(PAYLOAD), PAYLOAD};

  logic [CNT_W-1:0] cnt;
  logic             full;
  logic             take;
  logic             acc_bit;

  id_bit_counter #(.NBITS(ID_W), .READY_AT(PAY_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .shift_i (shift_i),
    .cnt_o   (cnt),
    .full_o  (full),
    .ready_o (crc_ready_o)
  );

  id_serializer #(.IDENT(IDENT)) u_ser (
    .cnt_i  (cnt),
    .full_i (full),
    .bit_o  (tx_bit_o)
  );

  assign take    = shift_i && !full;
  assign acc_bit = check_mode_i ? rx_bit_i : tx_bit_o;

  crc8_shifter u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .step_i  (take),
    .din_i   (acc_bit),
    .crc_o   (crc_o)
  );

  assign match_o = full && (crc_o == '0);

  p_match_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_o) |-> $past(shift_i && !clear_i));
  p_ready_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_ready_o |-> !match_o);
  p_full_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !clear_i) |=> match_o && crc_o == '0);
endmodule

// File: tb/serial_id_crc_tb.sv
module serial_id_crc_tb;
  localparam logic [7:0]  FAM = 8'h0F;
  localparam logic [47:0] SER = 48'hA1B2_C3D4_E5F6;
  localparam int NV = 6;
  localparam logic [55:0] V_PAY [NV] = '{
    {48'hA1B2_C3D4_E5F6, 8'h0F}, 56'h0, {56{1'b1}},
    {48'h0000_0000_0001, 8'h0F}, {48'h1234_5678_9ABC, 8'h0F}, {48'h0F0F_0F0F_0F0F, 8'h0F}};
  localparam logic [63:0] V_FLIP [NV] = '{
    64'h0, 64'h0, 64'h0, 64'h1, 64'h8000_0000_0000_0000, 64'h0000_0100_0000_0000};

  logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0, shift = 1'b0, mode = 1'b0, rx = 1'b0;
  logic tx, ready, match;
  logic [7:0] crc;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_id_crc #(.FAMILY_CODE(FAM), .SERIAL_NUM(SER)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .shift_i(shift),
    .check_mode_i(mode), .rx_bit_i(rx), .tx_bit_o(tx), .crc_o(crc),
    .crc_ready_o(ready), .match_o(match));

  function automatic logic [7:0] ref_crc(input logic [55:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic fb = c[0] ^ d[i];
      c = {1'b0, c[7:1]};
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    @(negedge clk); rx = b; shift = 1'b1;
    @(negedge clk); shift = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  initial begin
    logic [63:0] own;
    own = {ref_crc({SER, FAM}), SER, FAM};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    chk("R7 crc", crc, 8'h00);
    chk("R7 ready", {7'b0, ready}, 8'h0);
    chk("R7 match", {7'b0, match}, 8'h0);
    chk("R7 tx", {7'b0, tx}, {7'b0, own[0]});

    // R1/R2/R8 emit own identity
    mode = 1'b0;
    for (int i = 0; i < 64; i++) begin
      chk("R1 tx bit", {7'b0, tx}, {7'b0, own[i]});
      if (i == 56) begin
        chk("R2 crc at 56", crc, own[63:56]);
        chk("R2 ready", {7'b0, ready}, 8'h1);
      end
      if (i == 55) chk("R2 not ready at 55", {7'b0, ready}, 8'h0);
      pulse(1'b0);
    end
    chk("R8 emit residue", crc, 8'h00);
    chk("R8 emit match", {7'b0, match}, 8'h1);
    chk("R1 idle high", {7'b0, tx}, 8'h1);
    // R6 extra strobes ignored
    pulse(1'b1); pulse(1'b0);
    chk("R6 crc after extra", crc, 8'h00);
    chk("R6 match after extra", {7'b0, match}, 8'h1);

    // R4 clear
    do_clear();
    chk("R4 crc cleared", crc, 8'h00);
    chk("R4 match cleared", {7'b0, match}, 8'h0);
    chk("R4 tx restart", {7'b0, tx}, {7'b0, own[0]});

    // R8/R5 check-mode table
    mode = 1'b1;
    for (int v = 0; v < NV; v++) begin
      logic [63:0] w;
      w = {ref_crc(V_PAY[v]), V_PAY[v]} ^ V_FLIP[v];
      do_clear();
      for (int i = 0; i < 64; i++) begin
        if (i == 56) chk("R2 check crc at 56", crc, ref_crc(w[55:0]));
        pulse(w[i]);
      end
      chk("R8 table match", {7'b0, match}, {7'b0, V_FLIP[v] == 64'h0});
    end

    // R5 zero residue but only 63 bits
    do_clear();
    for (int i = 0; i < 63; i++) pulse(1'b0);
    chk("R5 residue zero", crc, 8'h00);
    chk("R5 no match at 63", {7'b0, match}, 8'h0);
    pulse(1'b0);
    chk("R5 match at 64", {7'b0, match}, 8'h1);

    // R3 no strobe -> no change
    do_clear();
    pulse(1'b1); pulse(1'b1); pulse(1'b0);
    begin
      logic [7:0] c0; logic t0;
      c0 = crc; t0 = tx;
      @(negedge clk); rx = 1'b1;
      repeat (4) @(negedge clk);
      chk("R3 crc held", crc, c0);
      chk("R3 tx held", {7'b0, tx}, {7'b0, t0});
      chk("R3 ready held", {7'b0, ready}, 8'h0);
    end

    // R4 clear beats shift
    @(negedge clk); clear = 1'b1; shift = 1'b1; rx = 1'b1;
    @(negedge clk); clear = 1'b0; shift = 1'b0;
    chk("R4 clear priority crc", crc, 8'h00);
    mode = 1'b0;
    chk("R4 clear priority tx", {7'b0, tx}, {7'b0, own[0]});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule